// File: doc/BRIEF.md
# Address wrap detect and save

This block watches each update of the storage address and raises a sticky wrap flag when the update runs past the top of the installed memory. For the largest memory size, the wrap is the carry out of the most significant address position. For the three smaller sizes, the wrap is any set address bit above the installed capacity. The flag can be set only while the I/J register pair supplies the address.

Microcode has three commands for the flag. The store command copies the flag into a one-bit save latch. The restore command copies the save latch back into the flag. The test command drives a branch bit to 1 when the flag is set. When the test command is absent, or the flag is clear, the branch bit follows the ordinary microcode condition input.

Top module: `addr_wrap_guard`

## Requirements
- R1: A cycle with `rst` high clears both the wrap flag and the save latch. After that edge, `wrap_flag` reads 0, and a restore with no store in between leaves it at 0.
- R2: With `mem_size` = 3 (64K), an update that has `addr_upd`=1, `ij_src`=1 and `addr_carry`=1 sets the flag at the next edge. In this size `addr_hi` has no effect.
- R3: With `mem_size` = 0, 1 or 2 (8K, 16K, 32K), an update sets the flag when `addr_hi[2:mem_size]` is nonzero. `addr_hi[2]` is address bit 15 and `addr_hi[0]` is bit 13. Bits below that range have no effect, and neither does `addr_carry`.
- R4: The flag is never set by an update unless `addr_upd`=1 and `ij_src`=1 in the same cycle.
- R5: Once set, the flag stays set until a reset or a restore.
- R6: `cmd_store` loads the save latch with the flag value present in that cycle.
- R7: `cmd_restore` loads the flag with the save latch value, and this can clear a set flag.
- R8: When a restore and a wrap-setting update occur in the same cycle, the restore decides the new flag value.
- R9: A store and a restore in the same cycle exchange the flag and the save latch.
- R10: `branch_bit` is 1 when `cmd_test`=1 and the flag is set. In every other case it equals `cond_bit`, combinationally in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous machine reset, active high |
| addr_upd | input | 1 | An address update occurs this cycle |
| ij_src | input | 1 | The I/J pair is the current address source |
| addr_carry | input | 1 | Carry out of the top address position on update |
| addr_hi | input | 3 | Address bits 15..13 (bit 2 = address bit 15) |
| mem_size | input | 2 | 0=8K, 1=16K, 2=32K, 3=64K |
| cmd_store | input | 1 | Copy the flag into the save latch |
| cmd_restore | input | 1 | Copy the save latch into the flag |
| cmd_test | input | 1 | Test the flag onto the branch bit |
| cond_bit | input | 1 | Normal microcode branch condition |
| wrap_flag | output | 1 | Sticky wrap flag |
| branch_bit | output | 1 | Resulting branch bit |

## Verification
The save latch has no port of its own, so its contents are seen only by restoring them into the flag. The hardest cases to reach are the same-cycle exchange of store and restore, and a restore that overrides a wrap-setting update. The stimulus first builds known, opposite values in the flag and the save latch. It then issues the colliding commands and reads the result with a following restore or test. A reset placed between a store and a restore shows that the save latch is cleared as well.

// File: rtl/addr_wrap_pkg.sv
package addr_wrap_pkg;
    typedef struct packed {
        logic wrap;
        logic saved;
    } wrap_st_t;
endpackage

// File: rtl/wrap_detect.sv
module wrap_detect #(
    parameter int HI_W = 3,
    localparam int SZ_W = $clog2(HI_W + 1)
) (
    input  logic            addr_upd,
    input  logic            ij_src,
    input  logic            addr_carry,
    input  logic [HI_W-1:0] addr_hi,
    input  logic [SZ_W-1:0] mem_size,
    output logic            wrap_hit
);
    // over_sel[k] for k < HI_W: some bit above a capacity of 8K*2^k is set
    // over_sel[HI_W]: full-size memory, carry out of top position
    logic [HI_W:0] over_sel;

    for (genvar k = 0; k < HI_W; k++) begin : g_size
        assign over_sel[k] = |addr_hi[HI_W-1:k];
    end
    assign over_sel[HI_W] = addr_carry;

    always_comb begin
        wrap_hit = addr_upd && ij_src && over_sel[mem_size];
    end
endmodule

// File: rtl/wrap_regs.sv
module wrap_regs
    import addr_wrap_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic wrap_hit,
    input  logic cmd_store,
    input  logic cmd_restore,
    output logic wrap_q,
    output logic saved_q
);
    wrap_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cmd_store) begin
            st_d.saved = st_q.wrap;
        end
        if (cmd_restore) begin
            st_d.wrap = st_q.saved;
        end else if (wrap_hit) begin
            st_d.wrap = 1'b1;
        end
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign wrap_q  = st_q.wrap;
    assign saved_q = st_q.saved;
endmodule

// File: rtl/addr_wrap_guard.sv
module addr_wrap_guard #(
    parameter int HI_W = 3,
    localparam int SZ_W = $clog2(HI_W + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            addr_upd,
    input  logic            ij_src,
    input  logic            addr_carry,
    input  logic [HI_W-1:0] addr_hi,
    input  logic [SZ_W-1:0] mem_size,
    input  logic            cmd_store,
    input  logic            cmd_restore,
    input  logic            cmd_test,
    input  logic            cond_bit,
    output logic            wrap_flag,
    output logic            branch_bit
);
    logic wrap_hit;
    logic saved_q;

    wrap_detect #(.HI_W(HI_W)) u_detect (
        .addr_upd   (addr_upd),
        .ij_src     (ij_src),
        .addr_carry (addr_carry),
        .addr_hi    (addr_hi),
        .mem_size   (mem_size),
        .wrap_hit   (wrap_hit)
    );

    wrap_regs u_regs (
        .clk         (clk),
        .rst         (rst),
        .wrap_hit    (wrap_hit),
        .cmd_store   (cmd_store),
        .cmd_restore (cmd_restore),
        .wrap_q      (wrap_flag),
        .saved_q     (saved_q)
    );

    always_comb begin
        branch_bit = cond_bit;
        if (cmd_test && wrap_flag) begin
            branch_bit = 1'b1;
        end
    end
endmodule

// File: rtl/addr_wrap_chk.sv
module addr_wrap_chk (
    input logic clk,
    input logic rst,
    input logic addr_upd,
    input logic ij_src,
    input logic cmd_store,
    input logic cmd_restore,
    input logic cmd_test,
    input logic cond_bit,
    input logic wrap_flag,
    input logic saved_q,
    input logic branch_bit
);
    // R1
    reset_clears_chk: assert property (@(posedge clk) rst |=> !wrap_flag && !saved_q);
    // R4
    no_spurious_set_chk: assert property (@(posedge clk) disable iff (rst)
        !wrap_flag && !(addr_upd && ij_src) && !cmd_restore |=> !wrap_flag);
    // R5
    sticky_chk: assert property (@(posedge clk) disable iff (rst)
        wrap_flag && !cmd_restore |=> wrap_flag);
    // R6
    store_copy_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_store |=> saved_q == $past(wrap_flag));
    // R8
    restore_wins_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_restore |=> wrap_flag == $past(saved_q));
    // R10
    test_force_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_test && wrap_flag |-> branch_bit);
    // R10
    cond_pass_chk: assert property (@(posedge clk) disable iff (rst)
        !cmd_test |-> branch_bit == cond_bit);
endmodule

bind addr_wrap_guard addr_wrap_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .addr_upd    (addr_upd),
    .ij_src      (ij_src),
    .cmd_store   (cmd_store),
    .cmd_restore (cmd_restore),
    .cmd_test    (cmd_test),
    .cond_bit    (cond_bit),
    .wrap_flag   (wrap_flag),
    .saved_q     (saved_q),
    .branch_bit  (branch_bit)
);

// File: tb/tb_addr_wrap_guard.sv
module tb_addr_wrap_guard;
    logic clk = 1'b0;
    logic rst, addr_upd, ij_src, addr_carry, cmd_store, cmd_restore, cmd_test, cond_bit;
    logic [2:0] addr_hi;
    logic [1:0] mem_size;
    logic wrap_flag, branch_bit;

    always #10 clk = ~clk;

    addr_wrap_guard dut (.*);

    typedef struct {
        logic  br;
        logic  wr;
        string tag;
    } exp_t;
    exp_t sbq[$];

    int tests = 0, fails = 0;
    logic m_wrap = 1'b0, m_saved = 1'b0;

    task automatic step(input logic r, upd, ij, cy, input logic [2:0] hi,
                        input logic [1:0] sz, input logic st, rs, ts, cd,
                        input string tag);
        logic ev, nw, ns;
        exp_t e;
        @(negedge clk);
        rst = r; addr_upd = upd; ij_src = ij; addr_carry = cy; addr_hi = hi;
        mem_size = sz; cmd_store = st; cmd_restore = rs; cmd_test = ts; cond_bit = cd;
        if (sz == 2'd3) ev = cy;
        else ev = ((hi >> sz) != 3'd0);
        ev = ev && upd && ij;
        e.br  = (ts && m_wrap) ? 1'b1 : cd;
        nw = rs ? m_saved : (m_wrap || ev);
        ns = st ? m_wrap : m_saved;
        if (r) begin nw = 1'b0; ns = 1'b0; end
        m_wrap = nw; m_saved = ns;
        e.wr  = nw;
        e.tag = tag;
        sbq.push_back(e);
    endtask

    task automatic idle(input string tag);
        step(0, 0, 0, 0, 3'd0, 2'd3, 0, 0, 0, 0, tag);
    endtask

    initial begin : monitor
        exp_t e;
        forever begin
            @(negedge clk);
            #5;
            if (sbq.size() != 0) begin
                e = sbq[0];
                tests++;
                if (branch_bit !== e.br) begin
                    fails++;
                    $display("FAIL %s branch_bit actual=%b expected=%b", e.tag, branch_bit, e.br);
                end
                @(posedge clk);
                #5;
                tests++;
                if (wrap_flag !== e.wr) begin
                    fails++;
                    $display("FAIL %s wrap_flag actual=%b expected=%b", e.tag, wrap_flag, e.wr);
                end
                void'(sbq.pop_front());
            end
        end
    end

    initial begin : watchdog
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : driver
        step(1, 0, 0, 0, 3'd0, 2'd3, 0, 0, 0, 0, "R1 reset");
        step(1, 0, 0, 0, 3'd0, 2'd3, 0, 0, 0, 0, "R1 reset");
        step(0, 1, 1, 0, 3'd7, 2'd3, 0, 0, 0, 0, "R2 64K high bits ignored");
        step(0, 1, 0, 1, 3'd0, 2'd3, 0, 0, 0, 0, "R4 not IJ source");
        step(0, 0, 1, 1, 3'd0, 2'd3, 0, 0, 0, 0, "R4 no update");
        step(0, 0, 0, 0, 3'd0, 2'd3, 0, 0, 1, 1, "R10 test clear uses cond");
        step(0, 1, 1, 1, 3'd0, 2'd3, 0, 0, 0, 0, "R2 64K carry sets");
        idle("R5 sticky");
        step(0, 0, 0, 0, 3'd0, 2'd3, 0, 0, 1, 0, "R10 test set forces 1");
        step(0, 0, 0, 0, 3'd0, 2'd3, 0, 0, 0, 0, "R10 no test passes cond 0");
        step(0, 0, 0, 0, 3'd0, 2'd3, 1, 0, 0, 1, "R6 store set");
        step(1, 0, 0, 0, 3'd0, 2'd3, 0, 0, 0, 0, "R1 reset mid run");
        step(0, 0, 0, 0, 3'd0, 2'd3, 0, 0, 1, 0, "R10 test after reset");
        step(0, 0, 0, 0, 3'd0, 2'd3, 0, 1, 0, 0, "R1 save latch cleared");
        step(0, 1, 1, 1, 3'd0, 2'd0, 0, 0, 0, 0, "R3 8K carry ignored");
        step(0, 1, 1, 0, 3'd1, 2'd1, 0, 0, 0, 0, "R3 16K low bit ignored");
        step(0, 1, 1, 0, 3'd3, 2'd2, 0, 0, 0, 0, "R3 32K low bits ignored");
        step(0, 1, 1, 0, 3'd2, 2'd1, 0, 0, 0, 0, "R3 16K bit14 sets");
        step(1, 0, 0, 0, 3'd0, 2'd3, 0, 0, 0, 0, "R1 reset");
        step(0, 1, 1, 0, 3'd4, 2'd2, 0, 0, 0, 0, "R3 32K bit15 sets");
        step(1, 0, 0, 0, 3'd0, 2'd3, 0, 0, 0, 0, "R1 reset");
        step(0, 1, 1, 0, 3'd1, 2'd0, 0, 0, 0, 0, "R3 8K bit13 sets");
        step(0, 0, 0, 0, 3'd0, 2'd3, 0, 1, 0, 0, "R7 restore clears");
        step(0, 0, 0, 0, 3'd0, 2'd3, 0, 1, 0, 0, "R7 restore clear again");
        step(0, 1, 1, 1, 3'd0, 2'd3, 0, 1, 0, 0, "R8 restore beats set");
        step(0, 1, 1, 1, 3'd0, 2'd3, 0, 0, 0, 0, "R2 set again");
        step(0, 0, 0, 0, 3'd0, 2'd3, 1, 1, 0, 0, "R9 swap");
        step(0, 0, 0, 0, 3'd0, 2'd3, 0, 0, 1, 0, "R9 flag now clear");
        step(0, 0, 0, 0, 3'd0, 2'd3, 0, 1, 0, 0, "R9 saved held old flag");
        step(0, 0, 0, 0, 3'd0, 2'd3, 1, 0, 1, 0, "R6 store while set");
        step(0, 1, 1, 0, 3'd0, 2'd0, 0, 1, 0, 0, "R8 restore set value");
        idle("R5 hold");
        while (sbq.size() != 0) @(negedge clk);
        @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule